// File: doc/BRIEF.md
# Segmented Address Translator with Associative Page Cache

This block turns a 32-bit processor virtual address into a physical address. The top three address bits select one of four fixed regions. Two kernel windows are mapped straight onto the lowest 512 MB of physical space, one cached and one uncached, with no table lookup. The user region and the upper kernel region are translated through a small fully associative translation cache. Software fills that cache through a write port that takes an index and the entry fields.

On each cycle the block takes an address, a write flag, a user-mode bit and the current address-space tag. One cycle later it presents the physical address, a cacheable flag, the page's stored no-cache bit, and three fault flags: miss, write to a read-only page, and privilege violation. Refill, replacement and exception vectoring are left to software. A flush input invalidates every entry in a single cycle. It is meant for context switches when address-space tags are not in use.

Top module: `mmu_xlate_top`

## Requirements
- R1: While reset is high, every output is 0. Reset also invalidates every cache entry.
- R2: For a kernel-mode access with address bits [31:29] = 3'b100, the physical address is {3'b000, va[28:0]}, cacheable is 1 and no fault is raised, whatever the cache holds.
- R3: For a kernel-mode access with address bits [31:29] = 3'b101, the physical address is {3'b000, va[28:0]}, cacheable is 0 and no fault is raised.
- R4: Addresses with va[31] = 0 or va[31:30] = 2'b11 are translated through the cache. An entry matches when it is valid, its page number equals va[31:12], and either its global bit is 1 or its tag equals the current tag. On a match the result is {page frame, va[11:0]} with cacheable = 1.
- R5: A cache-translated access that no entry matches sets tlb_miss. It drives the physical address, cacheable and page_nocache to 0.
- R6: A write that hits an entry whose writable bit is 0 sets ro_fault and still reports the translated address. A read of such a page, or any access through a direct window, raises no ro_fault.
- R7: A user-mode access with va[31] = 1 sets priv_fault. It gives physical address 0, cacheable 0 and no other fault, even when a cache entry would match.
- R8: The no-cache bit of the matching entry appears on page_nocache. It does not change cacheable or the match.
- R9: When several entries match, the entry with the lowest index supplies the translation.
- R10: A write through the load port takes effect at the clock edge. A lookup in the same cycle still sees the old contents, and a lookup in the next cycle sees the new entry. Index 0 and the last index (63) are both usable.
- R11: A flush invalidates all entries in one cycle. A load issued in the same cycle as the flush is kept.
- R12: At most one of priv_fault, tlb_miss and ro_fault is 1 in any cycle.
- R13: Every result is registered: the outputs reflect the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va | input | 32 | Virtual address to translate |
| is_write | input | 1 | 1 for a store access |
| user_mode | input | 1 | 1 when the processor runs in user mode |
| cur_asid | input | 6 | Current address-space tag |
| ld_en | input | 1 | Load one cache entry this cycle |
| ld_idx | input | 6 | Entry index to load |
| ld_vpn | input | 20 | Virtual page number of the loaded entry |
| ld_pfn | input | 20 | Physical frame number of the loaded entry |
| ld_asid | input | 6 | Address-space tag of the loaded entry |
| ld_global | input | 1 | Entry matches any tag |
| ld_valid | input | 1 | Entry is valid |
| ld_writable | input | 1 | Entry permits stores |
| ld_nocache | input | 1 | Stored no-cache bit |
| flush | input | 1 | Invalidate all entries |
| pa | output | 32 | Physical address |
| cacheable | output | 1 | Access may use the cache |
| page_nocache | output | 1 | No-cache bit of the matching entry |
| tlb_miss | output | 1 | No entry matched |
| ro_fault | output | 1 | Store to a read-only page |
| priv_fault | output | 1 | User access to a kernel region |

## Verification
A stale or corrupted valid bit shows as a miss, or as a wrong frame number on pa, in the cycle after the first lookup of the affected page. The same applies when the tag or global comparison is wrong. A faulty priority encoder only shows when two entries share a page. The bench therefore loads a duplicate pair at indices 10 and 20 and expects the lower frame. Segment decode errors show on the next cycle as a wrong cacheable flag or wrong high address bits in the direct windows. The flush and load ordering is probed with a load and a flush in the same cycle, followed by lookups of both the old page and the newly loaded page.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int VA_W     = 32;
    localparam int PG_OFS_W = 12;
    localparam int PN_W     = VA_W - PG_OFS_W;
    localparam int ASID_W   = 6;
    localparam int DIRECT_W = 29;

    typedef struct packed {
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   pfn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              valid;
        logic              writable;
        logic              nocache;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        SEG_USER_MAP   = 2'd0,
        SEG_K_CACHED   = 2'd1,
        SEG_K_UNCACHED = 2'd2,
        SEG_K_MAP      = 2'd3
    } seg_e;

    typedef struct packed {
        logic [VA_W-1:0] pa;
        logic            cacheable;
        logic            nocache;
        logic            miss;
        logic            ro;
        logic            priv;
    } xlate_res_t;

    function automatic seg_e seg_of(input logic [VA_W-1:0] addr);
        case (addr[VA_W-1 -: 3])
            3'b100:         return SEG_K_CACHED;
            3'b101:         return SEG_K_UNCACHED;
            3'b110, 3'b111: return SEG_K_MAP;
            default:        return SEG_USER_MAP;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] direct_pa(input logic [VA_W-1:0] addr);
        return {{(VA_W-DIRECT_W){1'b0}}, addr[DIRECT_W-1:0]};
    endfunction
endpackage

// File: rtl/mmu_seg_decode.sv
module mmu_seg_decode
    import mmu_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            user_mode,
    output seg_e            seg,
    output logic            needs_tlb,
    output logic            priv_viol,
    output logic [VA_W-1:0] win_pa
);
    always_comb begin
        seg       = seg_of(va);
        needs_tlb = (seg == SEG_USER_MAP) || (seg == SEG_K_MAP);
        priv_viol = user_mode && (seg != SEG_USER_MAP);
        win_pa    = direct_pa(va);
    end
endmodule

// File: rtl/mmu_tlb_cam.sv
module mmu_tlb_cam
    import mmu_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic              flush,
    input  logic [PN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              hit,
    output tlb_ent_t          hit_ent
);
    tlb_ent_t         ent_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] match;
    logic [IDX_W-1:0] hit_idx;

    // Valid bits: flush clears all, a load in the same cycle lands after it.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (flush) valid_q <= '0;
            if (wr_en) valid_q[wr_idx] <= wr_ent.valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wr_idx] <= wr_ent;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_q[g]
                       && (ent_q[g].vpn == lk_vpn)
                       && (ent_q[g].glob || (ent_q[g].asid == lk_asid));
    end

    // Lowest matching index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit     = |match;
        hit_ent = ent_q[hit_idx];
    end
endmodule

// File: rtl/mmu_resolve.sv
module mmu_resolve
    import mmu_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            is_write,
    input  seg_e            seg,
    input  logic            needs_tlb,
    input  logic            priv_viol,
    input  logic [VA_W-1:0] win_pa,
    input  logic            hit,
    input  tlb_ent_t        hit_ent,
    output xlate_res_t      res
);
    always_comb begin
        res = '0;
        if (priv_viol) begin
            res.priv = 1'b1;
        end else if (!needs_tlb) begin
            res.pa        = win_pa;
            res.cacheable = (seg == SEG_K_CACHED);
        end else if (!hit) begin
            res.miss = 1'b1;
        end else begin
            res.pa        = {hit_ent.pfn, va[PG_OFS_W-1:0]};
            res.cacheable = 1'b1;
            res.nocache   = hit_ent.nocache;
            res.ro        = is_write && !hit_ent.writable;
        end
    end
endmodule

// File: rtl/mmu_xlate_top.sv
module mmu_xlate_top
    import mmu_pkg::*;
#(
    parameter int TLB_DEPTH = 64,
    localparam int IDX_W = $clog2(TLB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       va,
    input  logic              is_write,
    input  logic              user_mode,
    input  logic [5:0]        cur_asid,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [19:0]       ld_vpn,
    input  logic [19:0]       ld_pfn,
    input  logic [5:0]        ld_asid,
    input  logic              ld_global,
    input  logic              ld_valid,
    input  logic              ld_writable,
    input  logic              ld_nocache,
    input  logic              flush,
    output logic [31:0]       pa,
    output logic              cacheable,
    output logic              page_nocache,
    output logic              tlb_miss,
    output logic              ro_fault,
    output logic              priv_fault
);
    seg_e            seg;
    logic            needs_tlb, priv_viol, hit;
    logic [VA_W-1:0] win_pa;
    tlb_ent_t        ld_ent, hit_ent;
    xlate_res_t      res_d, res_q;

    assign ld_ent = '{vpn: ld_vpn, pfn: ld_pfn, asid: ld_asid, glob: ld_global,
                      valid: ld_valid, writable: ld_writable, nocache: ld_nocache};

    mmu_seg_decode u_seg (
        .va(va), .user_mode(user_mode), .seg(seg),
        .needs_tlb(needs_tlb), .priv_viol(priv_viol), .win_pa(win_pa)
    );

    mmu_tlb_cam #(.DEPTH(TLB_DEPTH)) u_cam (
        .clk(clk), .rst(rst), .wr_en(ld_en), .wr_idx(ld_idx), .wr_ent(ld_ent),
        .flush(flush), .lk_vpn(va[VA_W-1:PG_OFS_W]), .lk_asid(cur_asid),
        .hit(hit), .hit_ent(hit_ent)
    );

    mmu_resolve u_res (
        .va(va), .is_write(is_write), .seg(seg), .needs_tlb(needs_tlb),
        .priv_viol(priv_viol), .win_pa(win_pa), .hit(hit), .hit_ent(hit_ent),
        .res(res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign pa           = res_q.pa;
    assign cacheable    = res_q.cacheable;
    assign page_nocache = res_q.nocache;
    assign tlb_miss     = res_q.miss;
    assign ro_fault     = res_q.ro;
    assign priv_fault   = res_q.priv;
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] va,
    input logic        is_write,
    input logic        user_mode,
    input logic [31:0] pa,
    input logic        cacheable,
    input logic        page_nocache,
    input logic        tlb_miss,
    input logic        ro_fault,
    input logic        priv_fault
);
    // R7, R13
    assert_user_kernel_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (user_mode && va[31]) |=> (priv_fault && pa == 32'h0 && !cacheable));

    // R2, R13
    assert_cached_window_R2: assert property (@(posedge clk) disable iff (rst)
        (!user_mode && va[31:29] == 3'b100) |=>
        (cacheable && !tlb_miss && !ro_fault && pa == {3'b000, $past(va[28:0])}));

    // R3
    assert_uncached_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!user_mode && va[31:29] == 3'b101) |=>
        (!cacheable && !tlb_miss && !ro_fault && pa == {3'b000, $past(va[28:0])}));

    // R12
    assert_single_fault_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({priv_fault, tlb_miss, ro_fault}));

    // R6
    assert_ro_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
        ro_fault |-> $past(is_write));

    // R5
    assert_miss_clears_result_R5: assert property (@(posedge clk) disable iff (rst)
        tlb_miss |-> (pa == 32'h0 && !cacheable && !page_nocache));
endmodule

bind mmu_xlate_top mmu_xlate_chk chk_i (
    .clk(clk), .rst(rst), .va(va), .is_write(is_write), .user_mode(user_mode),
    .pa(pa), .cacheable(cacheable), .page_nocache(page_nocache),
    .tlb_miss(tlb_miss), .ro_fault(ro_fault), .priv_fault(priv_fault)
);

// File: tb/mmu_xlate_top_tb_top.sv
module mmu_xlate_top_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic [31:0] va = '0;
    logic        is_write = 0, user_mode = 0;
    logic [5:0]  cur_asid = '0;
    logic        ld_en = 0, ld_global = 0, ld_valid = 0, ld_writable = 0, ld_nocache = 0, flush = 0;
    logic [5:0]  ld_idx = '0, ld_asid = '0;
    logic [19:0] ld_vpn = '0, ld_pfn = '0;
    logic [31:0] pa;
    logic        cacheable, page_nocache, tlb_miss, ro_fault, priv_fault;

    mmu_xlate_top dut_i (
        .clk(clk), .rst(rst), .va(va), .is_write(is_write), .user_mode(user_mode),
        .cur_asid(cur_asid), .ld_en(ld_en), .ld_idx(ld_idx), .ld_vpn(ld_vpn),
        .ld_pfn(ld_pfn), .ld_asid(ld_asid), .ld_global(ld_global), .ld_valid(ld_valid),
        .ld_writable(ld_writable), .ld_nocache(ld_nocache), .flush(flush),
        .pa(pa), .cacheable(cacheable), .page_nocache(page_nocache),
        .tlb_miss(tlb_miss), .ro_fault(ro_fault), .priv_fault(priv_fault)
    );

    int n_chk = 0, n_err = 0;

    function automatic logic [4:0] flags();
        return {cacheable, page_nocache, tlb_miss, ro_fault, priv_fault};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [5:0] asid, input logic g, input logic v,
                        input logic w, input logic nc);
        @(negedge clk);
        ld_en = 1; ld_idx = 6'(idx); ld_vpn = vpn; ld_pfn = pfn; ld_asid = asid;
        ld_global = g; ld_valid = v; ld_writable = w; ld_nocache = nc;
        @(negedge clk);
        ld_en = 0;
    endtask

    // Drive at a falling edge; result registered at the next rising edge; sample at the falling edge after.
    task automatic access(input logic [31:0] a, input logic wr, input logic usr, input logic [5:0] id);
        @(negedge clk);
        va = a; is_write = wr; user_mode = usr; cur_asid = id;
        @(negedge clk);
    endtask

    // {va, write, user, asid, expected pa, flags {cacheable,nocache,miss,ro,priv}, requirement}
    localparam int NV = 16;
    localparam logic [80:0] VECS [NV] = '{
        {32'h00400ABC, 1'b0, 1'b0, 6'd5, 32'h12345ABC, 5'b10000, 4'd4},  // R4 tag match
        {32'h00400ABC, 1'b0, 1'b0, 6'd6, 32'h00000000, 5'b00100, 4'd5},  // R5 tag mismatch
        {32'h00401123, 1'b0, 1'b1, 6'd2, 32'h0ABCD123, 5'b11000, 4'd8},  // R8 global, nocache reported
        {32'h00401123, 1'b1, 1'b1, 6'd2, 32'h0ABCD123, 5'b11010, 4'd6},  // R6 write to read-only
        {32'h00400ABC, 1'b1, 1'b1, 6'd5, 32'h12345ABC, 5'b10000, 4'd6},  // R6 write to writable
        {32'h80001234, 1'b0, 1'b0, 6'd0, 32'h00001234, 5'b10000, 4'd2},  // R2
        {32'h9FFFFFFF, 1'b0, 1'b0, 6'd0, 32'h1FFFFFFF, 5'b10000, 4'd2},  // R2 top edge
        {32'hA0000010, 1'b1, 1'b0, 6'd0, 32'h00000010, 5'b00000, 4'd3},  // R3
        {32'hBFC00000, 1'b0, 1'b0, 6'd0, 32'h1FC00000, 5'b00000, 4'd3},  // R3
        {32'hC0000008, 1'b0, 1'b0, 6'd1, 32'h00777008, 5'b10000, 4'd4},  // R4 upper kernel region
        {32'hC0000008, 1'b0, 1'b1, 6'd1, 32'h00000000, 5'b00001, 4'd7},  // R7 despite match
        {32'h80000000, 1'b0, 1'b1, 6'd0, 32'h00000000, 5'b00001, 4'd7},  // R7 lower edge
        {32'h00500000, 1'b0, 1'b0, 6'd5, 32'h00000000, 5'b00100, 4'd5},  // R5 invalid entry
        {32'h00600FFF, 1'b0, 1'b0, 6'd3, 32'h22222FFF, 5'b10000, 4'd9},  // R9 lowest index
        {32'h7FFFF001, 1'b0, 1'b0, 6'd7, 32'hFFFFF001, 5'b10000, 4'd10}, // R10 last index
        {32'h7FFFF001, 1'b0, 1'b0, 6'd6, 32'h00000000, 5'b00100, 4'd5}   // R5
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        va = 32'h80001234;
        repeat (3) @(negedge clk);
        check("R1 reset pa", pa, 0);
        check("R1 reset flags", flags(), 0);
        rst = 0;
        // R1: cache is empty after reset
        access(32'h00400ABC, 0, 0, 6'd5);
        check("R1 empty after reset", flags(), 5'b00100);

        load(0,  20'h00400, 20'h12345, 6'd5, 0, 1, 1, 0);
        load(1,  20'h00401, 20'h0ABCD, 6'd9, 1, 1, 0, 1);
        load(2,  20'hC0000, 20'h00777, 6'd0, 1, 1, 1, 0);
        load(3,  20'h00500, 20'h11111, 6'd5, 0, 0, 1, 0);
        load(20, 20'h00600, 20'h33333, 6'd3, 0, 1, 1, 0);
        load(10, 20'h00600, 20'h22222, 6'd3, 0, 1, 1, 0);
        load(63, 20'h7FFFF, 20'hFFFFF, 6'd7, 0, 1, 1, 0);

        for (int i = 0; i < NV; i++) begin
            logic [80:0] v;
            v = VECS[i];
            access(v[80:49], v[48], v[47], v[46:41]);
            check($sformatf("R%0d vec%0d pa", v[3:0], i), pa, v[40:9]);
            check($sformatf("R%0d vec%0d flags", v[3:0], i), flags(), v[8:4]);
            check($sformatf("R12 vec%0d faults", i), $countones({tlb_miss, ro_fault, priv_fault}) <= 1, 1);
        end

        // R10: a lookup in the load cycle sees old contents, the next cycle sees the new entry
        @(negedge clk);
        va = 32'h00700010; is_write = 0; user_mode = 0; cur_asid = 6'd4;
        ld_en = 1; ld_idx = 6'd5; ld_vpn = 20'h00700; ld_pfn = 20'h05555; ld_asid = 6'd4;
        ld_global = 0; ld_valid = 1; ld_writable = 1; ld_nocache = 0;
        @(negedge clk);
        ld_en = 0;
        check("R10 same-cycle lookup", flags(), 5'b00100);
        @(negedge clk);
        check("R10 next-cycle pa", pa, 32'h05555010);
        check("R13 next-cycle flags", flags(), 5'b10000);

        // R11: flush with a simultaneous load keeps only the load
        @(negedge clk);
        flush = 1; ld_en = 1; ld_idx = 6'd4; ld_vpn = 20'h00800; ld_pfn = 20'h44444;
        ld_asid = 6'd0; ld_global = 1; ld_valid = 1; ld_writable = 1; ld_nocache = 0;
        @(negedge clk);
        flush = 0; ld_en = 0;
        access(32'h00400ABC, 0, 0, 6'd5);
        check("R11 flushed entry", flags(), 5'b00100);
        access(32'h0060000C, 0, 0, 6'd3);
        check("R11 flushed duplicate", flags(), 5'b00100);
        access(32'h00800123, 0, 1, 6'd9);
        check("R11 kept load pa", pa, 32'h44444123);
        access(32'h80000040, 0, 0, 6'd0);
        check("R2 window after flush", pa, 32'h00000040);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule